// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral watches for a stalled processor. A 32-bit down-counter, clocked once per cycle while the block runs, counts from a programmable start value to zero. Reaching zero is an expiry. The counter then starts again from the start value, and the block raises a pending interrupt. Software services the watchdog by writing the clear register. That write drops the interrupt and restarts the count. If the counter runs out a second time before the interrupt is serviced, and reset generation is armed, the block drives a reset request. The request stays high until the block itself is reset.

Software reaches the block over a simple single-cycle register bus: an address, a write strobe, write data, and read data that follows the address within the same cycle. A key register guards every other register. While the block is locked, writes anywhere except the key register are dropped, so a runaway program cannot disarm the watchdog by accident.

Top module: `wdg_top`

## Requirements
- R1: After reset the block is locked, both control bits are clear, the start value and the counter both read 0xFFFFFFFF, no interrupt is pending, and the reset request is low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value there locks it. A read of 0xC00 returns 1 in bit 0 while locked and 0 while unlocked.
- R3: While the block is locked, bus writes to every offset other than 0xC00 leave all register contents unchanged.
- R4: When control bit 0 (run) is written to 1 while it was 0, the counter restarts from the start value and then drops by one per cycle. The counter reads at offset 0x004.
- R5: A cycle in which the block runs and the counter is zero is an expiry. On the next cycle the raw interrupt status (bit 0 at 0x010) reads 1 and the counter holds the start value again.
- R6: An expiry while the raw status is already set and control bit 1 (reset arm) is set raises the reset request, which then stays high whatever is written, until block reset.
- R7: An expiry while the raw status is set but reset arm is clear does not raise the reset request.
- R8: Any write to offset 0x00C, whatever its data, clears the raw status and restarts the counter from the start value.
- R9: The masked status (bit 0 at 0x014) and the interrupt output both equal raw status AND run.
- R10: While run is clear, the counter holds its value and neither the interrupt nor the reset request can be raised.
- R11: A write to the start value (offset 0x000) also loads that value into the counter on the next cycle.
- R12: The control register (offset 0x008) reads its two bits in positions 1:0 and zeros above them. The clear offset and all unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_o | output | 1 | Interrupt, equals masked status |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The hardest state to reach from the ports is the reset request. It needs the key write, a start value, both control bits, and then two full count periods with no clear write between them. The stimulus uses a start value of four, so each period takes only five cycles. It counts cycles exactly to reach the second expiry, and runs the same path once with reset arm clear. After that it services the interrupt, disables the block and locks it again to show the request stays sticky. A behavioural model in the bench tracks every register and output on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_START  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_KEY    = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_arm;
    logic run;
  } wdg_ctrl_t;
endpackage

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         reload_i,
  input  logic [W-1:0] reload_val_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = run_i & at_zero & ~reload_i;
  assign cnt_en   = reload_i | run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i)     cnt_d = reload_val_i;
    else if (at_zero) cnt_d = start_i;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !reload_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_expiry_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(start_i)));

  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clear_i,
  input  logic run_i,
  input  logic rst_arm_i,
  output logic raw_o,
  output logic masked_o,
  output logic rst_req_o
);
  logic raw_q, raw_d;
  logic rst_q, rst_d;
  logic raw_en, rst_en;

  assign raw_en = clear_i | expire_i;
  assign rst_en = expire_i & raw_q & rst_arm_i;

  always_comb begin
    raw_d = raw_q;
    if (clear_i)       raw_d = 1'b0;
    else if (expire_i) raw_d = 1'b1;
    rst_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (raw_en) raw_q <= raw_d;
      if (rst_en) rst_q <= rst_d;
    end
  end

  assign raw_o     = raw_q;
  assign masked_o  = raw_q & run_i;
  assign rst_req_o = rst_q;

  p_reset_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);

  p_reset_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> ($past(rst_arm_i) && $past(raw_q)));

  p_irq_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    masked_o |-> run_i);

  p_no_raise_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !raw_q) |=> !raw_q);
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int W  = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  cnt_i,
  input  logic          raw_i,
  input  logic          masked_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  start_o,
  output wdg_ctrl_t     ctrl_o,
  output logic          reload_o,
  output logic [W-1:0]  reload_val_o,
  output logic          clear_o
);
  localparam int PAD_CTRL = W - 2;
  localparam int PAD_BIT  = W - 1;

  logic      lock_q, lock_d;
  logic [W-1:0] start_q, start_d;
  wdg_ctrl_t ctrl_q, ctrl_d;
  logic      wr_ok;
  logic      wr_start, wr_ctrl, wr_clear, wr_key;
  logic      run_rise;

  assign wr_ok    = we_i & ~lock_q;
  assign wr_start = wr_ok & (addr_i == OFS_START);
  assign wr_ctrl  = wr_ok & (addr_i == OFS_CTRL);
  assign wr_clear = wr_ok & (addr_i == OFS_CLEAR);
  assign wr_key   = we_i  & (addr_i == OFS_KEY);
  assign run_rise = wr_ctrl & wdata_i[0] & ~ctrl_q.run;

  always_comb begin
    lock_d  = (wdata_i != UNLOCK_KEY);
    start_d = wdata_i;
    ctrl_d  = '{rst_arm: wdata_i[1], run: wdata_i[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b1;
      start_q <= '1;
      ctrl_q  <= '0;
    end else begin
      if (wr_key)   lock_q  <= lock_d;
      if (wr_start) start_q <= start_d;
      if (wr_ctrl)  ctrl_q  <= ctrl_d;
    end
  end

  assign reload_o     = wr_start | wr_clear | run_rise;
  assign reload_val_o = wr_start ? wdata_i : start_q;
  assign clear_o      = wr_clear;
  assign start_o      = start_q;
  assign ctrl_o       = ctrl_q;

  always_comb begin
    unique case (addr_i)
      OFS_START:  rdata_o = start_q;
      OFS_COUNT:  rdata_o = cnt_i;
      OFS_CTRL:   rdata_o = {{PAD_CTRL{1'b0}}, ctrl_q.rst_arm, ctrl_q.run};
      OFS_RAW:    rdata_o = {{PAD_BIT{1'b0}}, raw_i};
      OFS_MASKED: rdata_o = {{PAD_BIT{1'b0}}, masked_i};
      OFS_KEY:    rdata_o = {{PAD_BIT{1'b0}}, lock_q};
      default:    rdata_o = '0;
    endcase
  end

  p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFS_KEY && wdata_i == UNLOCK_KEY) |=> !lock_q);

  p_other_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFS_KEY && wdata_i != UNLOCK_KEY) |=> lock_q);

  p_locked_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(start_q));

  p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(ctrl_q));

  p_locked_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !clear_o);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] cnt, start, reload_val;
  wdg_ctrl_t         ctrl;
  logic              reload, clear, expire, raw, masked;

  wdg_regs #(.AW(ADDR_W), .W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (bus_addr),
    .we_i         (bus_we),
    .wdata_i      (bus_wdata),
    .cnt_i        (cnt),
    .raw_i        (raw),
    .masked_i     (masked),
    .rdata_o      (bus_rdata),
    .start_o      (start),
    .ctrl_o       (ctrl),
    .reload_o     (reload),
    .reload_val_o (reload_val),
    .clear_o      (clear)
  );

  wdg_counter #(.W(DATA_W)) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (ctrl.run),
    .reload_i     (reload),
    .reload_val_i (reload_val),
    .start_i      (start),
    .cnt_o        (cnt),
    .expire_o     (expire)
  );

  wdg_expiry u_expiry (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_i  (expire),
    .clear_i   (clear),
    .run_i     (ctrl.run),
    .rst_arm_i (ctrl.rst_arm),
    .raw_o     (raw),
    .masked_o  (masked),
    .rst_req_o (rst_req_o)
  );

  assign irq_o = masked;

  p_irq_tracks_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (raw & ctrl.run));
endmodule

// File: tb/wdg_top_tb.sv
module wdg_top_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .rst_req_o(rst_req_o)
  );

  // behavioural reference model
  logic [31:0] m_start, m_cnt;
  bit m_run, m_arm, m_raw, m_rst, m_lock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start <= 32'hFFFF_FFFF; m_cnt <= 32'hFFFF_FFFF;
      m_run <= 0; m_arm <= 0; m_raw <= 0; m_rst <= 0; m_lock <= 1;
    end else begin : step_model
      bit restart, open;
      logic [31:0] from;
      open = bus_we && !m_lock;
      restart = 0;
      from = m_start;
      if (bus_we && bus_addr == 12'hC00) m_lock <= (bus_wdata != KEY);
      if (open && bus_addr == 12'h000) begin
        m_start <= bus_wdata; restart = 1; from = bus_wdata;
      end
      if (open && bus_addr == 12'h008) begin
        if (bus_wdata[0] && !m_run) restart = 1;
        m_run <= bus_wdata[0]; m_arm <= bus_wdata[1];
      end
      if (open && bus_addr == 12'h00C) begin
        restart = 1; m_raw <= 0;
      end
      if (restart) m_cnt <= from;
      else if (m_run) begin
        if (m_cnt == 0) begin
          m_cnt <= m_start;
          m_raw <= 1;
          if (m_raw && m_arm) m_rst <= 1;
        end else m_cnt <= m_cnt - 1;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return m_start;
      12'h004: return m_cnt;
      12'h008: return {30'b0, m_arm, m_run};
      12'h010: return {31'b0, m_raw};
      12'h014: return {31'b0, m_raw & m_run};
      12'hC00: return {31'b0, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h000: return "R11";
      12'h004: return "R4";
      12'h010: return "R5";
      12'h014: return "R9";
      12'hC00: return "R2";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    check("R9", {31'b0, irq_o}, {31'b0, m_raw & m_run});
    check("R6", {31'b0, rst_req_o}, {31'b0, m_rst});
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      #1;
      compare_all();
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    step(1);
    bus_we = 1'b0;
  endtask

  task automatic peek(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a; bus_we = 1'b0;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    peek("R1", 12'hC00, 32'h1);
    peek("R1", 12'h000, 32'hFFFF_FFFF);
    peek("R1", 12'h004, 32'hFFFF_FFFF);
    peek("R1", 12'h008, 32'h0);
    peek("R1", 12'h010, 32'h0);
    check("R1", {30'b0, irq_o, rst_req_o}, 32'h0);

    // R3 writes dropped while locked
    wr(12'h000, 32'd5);
    peek("R3", 12'h000, 32'hFFFF_FFFF);
    wr(12'h008, 32'h3);
    peek("R3", 12'h008, 32'h0);
    peek("R3", 12'h004, 32'hFFFF_FFFF);

    // R2 wrong key keeps lock, right key opens
    wr(12'hC00, 32'h1234_5678);
    peek("R2", 12'hC00, 32'h1);
    wr(12'hC00, KEY);
    peek("R2", 12'hC00, 32'h0);

    // R11 start write loads counter
    wr(12'h000, 32'd4);
    peek("R11", 12'h004, 32'd4);

    // R4 enable rise restarts and counts down
    wr(12'h008, 32'h1);
    peek("R4", 12'h004, 32'd4);
    step(2);
    peek("R4", 12'h004, 32'd2);
    step(2);
    peek("R5", 12'h010, 32'h0);
    step(1);
    peek("R5", 12'h010, 32'h1);
    peek("R5", 12'h004, 32'd4);
    check("R9", {31'b0, irq_o}, 32'h1);

    // R7 second expiry without arm
    step(5);
    peek("R7", 12'h004, 32'd4);
    check("R7", {31'b0, rst_req_o}, 32'h0);

    // R8 clear with arbitrary data
    wr(12'h00C, 32'hDEAD_0000);
    peek("R8", 12'h010, 32'h0);
    peek("R8", 12'h004, 32'd4);

    // R12 reserved control bits, R6 armed second expiry
    wr(12'h008, 32'hFFFF_FFFF);
    peek("R12", 12'h008, 32'h3);
    peek("R12", 12'h00C, 32'h0);
    peek("R12", 12'h100, 32'h0);
    step(4);
    peek("R6", 12'h010, 32'h1);
    check("R6", {31'b0, rst_req_o}, 32'h0);
    step(4);
    check("R6", {31'b0, rst_req_o}, 32'h0);
    step(1);
    check("R6", {31'b0, rst_req_o}, 32'h1);
    wr(12'h00C, 32'h0);
    check("R6", {31'b0, rst_req_o}, 32'h1);

    // R9 masked status with run clear
    step(5);
    peek("R9", 12'h010, 32'h1);
    wr(12'h008, 32'h0);
    peek("R9", 12'h014, 32'h0);
    check("R9", {31'b0, irq_o}, 32'h0);
    peek("R9", 12'h010, 32'h1);

    // relock, R3 again
    wr(12'hC00, 32'h0);
    wr(12'h000, 32'd7);
    peek("R3", 12'h000, 32'd4);
    wr(12'h00C, 32'h1);
    peek("R3", 12'h010, 32'h1);

    // R10 hold while disabled from fresh reset
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h3);
    step(1);
    wr(12'h008, 32'h2);
    peek("R10", 12'h004, 32'd1);
    step(20);
    peek("R10", 12'h004, 32'd1);
    peek("R10", 12'h010, 32'h0);
    check("R10", {30'b0, irq_o, rst_req_o}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule